// File: doc/BRIEF.md
# GPIO controller with change interrupts

This block drives and samples up to 32 general-purpose lines from a small 32-bit register bus. Each line can be turned into an output or left as an input. A data register supplies the output levels, and reading it returns the present level of every line. A write-mask register picks which output bits a data write may alter, so software can change a single line without a read-modify-write sequence.

Every line is passed through a synchronizer. A change in either direction on a line is latched into a sticky change register, and software clears a bit there by writing a 1 to it. A per-line enable register gates these change bits onto one combined interrupt output. The number of lines is a parameter. Register bits at and above that count read as zero and ignore writes.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: After reset the direction, data, enable, change and type registers read 0, and the write-mask register reads all ones over the implemented lines. `pad_oe`, `pad_out` and `irq_out` are 0.
- R2: The direction register sits at byte offset 0x00. Bit i = 1 makes line i an output (`pad_oe[i]` = 1) and bit i = 0 makes it an input. The register reads back as written, and `pad_oe` follows on the clock edge of the write.
- R3: A write to the data register (offset 0x04) changes `pad_out[i]` only where bit i of the write-mask register (offset 0x10) is 1. Other bits keep their value. `pad_out` changes only on such a write.
- R4: A read of offset 0x04 returns the output register bit for output lines and the synchronized pad level for input lines. A pad change shows up in this read after two clock edges.
- R5: A rising or a falling transition on `pad_in[i]` sets bit i of the change register (offset 0x0C) on the third clock edge after the pad changes. The bit is not set before that edge.
- R6: Writing 1 to a bit of the change register clears it. Writing 0 leaves it unchanged.
- R7: If a new edge on a line reaches the change register on the same clock edge as a write-1 clear of that bit, the bit stays set.
- R8: `irq_out` is 1 exactly when some line has both its change bit and its enable bit (offset 0x08) set, where enable 1 unmasks the line. It follows register changes with no extra cycle.
- R9: Register bits at and above NUM_LINES read as 0 and ignore writes.
- R10: Offset 0x14 holds storage that reads back the value last written over the implemented lines. Its contents change neither `pad_out`, `pad_oe` nor `irq_out`.
- R11: Reads of unmapped or misaligned addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | NUM_LINES | Line levels seen at the pads |
| pad_out | output | NUM_LINES | Output levels towards the pads |
| pad_oe | output | NUM_LINES | Output enables towards the pads |
| irq_out | output | 1 | Combined change interrupt |

## Verification
Register writes take effect on the clock edge that samples the write. Read data and `irq_out` are combinational, so the bench samples them one time step after that edge, or at the falling edge of the next read. A pad change is driven at a falling edge. The data read is sampled after two rising edges. The change register is checked after two edges, where it must still be clear, and again after three edges, where the bit must be set. For the collision case, the clear write is placed on exactly the third edge after the pad change.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    localparam int BUS_W    = 32;
    localparam int SLOT_W   = 3;
    localparam int SLOT_LSB = 2;

    localparam logic [SLOT_W-1:0] SLOT_DIR   = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_DATA  = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_IEN   = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_CHG   = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_WMASK = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_TYPE  = 3'd5;

    typedef struct packed {
        logic              hit;
        logic              wr;
        logic [SLOT_W-1:0] slot;
    } bus_dec_t;

    function automatic logic slot_mapped(input logic [SLOT_W-1:0] s);
        return s <= SLOT_TYPE;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_LINES = 8,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] lvl,
    output logic [NUM_LINES-1:0] edge_det
);
    logic [NUM_LINES-1:0] stage_q [STAGES];
    logic [NUM_LINES-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= pad_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign lvl      = stage_q[STAGES-1];
    assign edge_det = stage_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_chg_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_dec_t             dec,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] out_q,
    output logic [NUM_LINES-1:0] ien_q,
    output logic [NUM_LINES-1:0] wmask_q,
    output logic [NUM_LINES-1:0] type_q
);
    logic we;
    assign we = dec.hit && dec.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            out_q   <= '0;
            ien_q   <= '0;
            wmask_q <= '1;
            type_q  <= '0;
        end else if (we) begin
            case (dec.slot)
                SLOT_DIR:   dir_q   <= wdata;
                SLOT_DATA:  out_q   <= (out_q & ~wmask_q) | (wdata & wmask_q);
                SLOT_IEN:   ien_q   <= wdata;
                SLOT_WMASK: wmask_q <= wdata;
                SLOT_TYPE:  type_q  <= wdata;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_chg_capture.sv
module gpio_chg_capture #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] edge_det,
    input  logic [NUM_LINES-1:0] clr,
    input  logic [NUM_LINES-1:0] ien,
    output logic [NUM_LINES-1:0] chg_q,
    output logic                 irq
);
    always_ff @(posedge clk) begin
        if (rst) chg_q <= '0;
        else     chg_q <= (chg_q & ~clr) | edge_det;
    end

    assign irq = |(chg_q & ien);

endmodule

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
    import gpio_chg_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq_out
);
    localparam int TOP_LSB = SLOT_LSB + SLOT_W;

    bus_dec_t             dec;
    logic [NUM_LINES-1:0] wd;
    logic [NUM_LINES-1:0] dir_q, out_q, ien_q, wmask_q, type_q;
    logic [NUM_LINES-1:0] lvl, edge_det, chg_q, chg_clr;
    logic [NUM_LINES-1:0] rd_lines;

    always_comb begin
        dec.slot = bus_addr[TOP_LSB-1:SLOT_LSB];
        dec.wr   = bus_sel && bus_wr;
        dec.hit  = (bus_addr[SLOT_LSB-1:0] == '0)
                && ((bus_addr >> TOP_LSB) == '0)
                && slot_mapped(bus_addr[TOP_LSB-1:SLOT_LSB]);
    end

    assign wd = bus_wdata[NUM_LINES-1:0];

    if (NUM_LINES < BUS_W) begin : g_hi_unused
        logic unused_hi;
        assign unused_hi = ^bus_wdata[BUS_W-1:NUM_LINES];
    end

    gpio_cfg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .wdata   (wd),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ien_q   (ien_q),
        .wmask_q (wmask_q),
        .type_q  (type_q)
    );

    gpio_in_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .lvl      (lvl),
        .edge_det (edge_det)
    );

    assign chg_clr = (dec.hit && dec.wr && dec.slot == SLOT_CHG) ? wd : '0;

    gpio_chg_capture #(.NUM_LINES(NUM_LINES)) u_chg (
        .clk      (clk),
        .rst      (rst),
        .edge_det (edge_det),
        .clr      (chg_clr),
        .ien      (ien_q),
        .chg_q    (chg_q),
        .irq      (irq_out)
    );

    always_comb begin
        rd_lines = '0;
        if (dec.hit) begin
            case (dec.slot)
                SLOT_DIR:   rd_lines = dir_q;
                SLOT_DATA:  rd_lines = (out_q & dir_q) | (lvl & ~dir_q);
                SLOT_IEN:   rd_lines = ien_q;
                SLOT_CHG:   rd_lines = chg_q;
                SLOT_WMASK: rd_lines = wmask_q;
                SLOT_TYPE:  rd_lines = type_q;
                default:    rd_lines = '0;
            endcase
        end
        bus_rdata = '0;
        bus_rdata[NUM_LINES-1:0] = rd_lines;
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_chg_ctrl_chk.sv
module gpio_chg_ctrl_chk #(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] chg,
    input logic [NUM_LINES-1:0] edge_det
);
    logic wr_dir, wr_data, wr_chg;
    assign wr_dir  = bus_sel && bus_wr && bus_addr == ADDR_W'(0);
    assign wr_data = bus_sel && bus_wr && bus_addr == ADDR_W'(4);
    assign wr_chg  = bus_sel && bus_wr && bus_addr == ADDR_W'(12);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0 && !irq_out));

    a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> pad_oe == $past(bus_wdata[NUM_LINES-1:0]));

    a_r3_out_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> $stable(pad_out));

    a_r5_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
        (chg & ~$past(chg) & ~$past(edge_det)) == '0);

    a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
        !wr_chg |=> ($past(chg) & ~chg) == '0);

    a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (chg & $past(edge_det)) == $past(edge_det));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata >> NUM_LINES) == '0);

endmodule

bind gpio_chg_ctrl gpio_chg_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out),
    .chg       (chg_q),
    .edge_det  (edge_det)
);

// File: tb/test_gpio_chg_ctrl.sv
module test_gpio_chg_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_DIR = 5'h00, A_DATA = 5'h04, A_IEN = 5'h08,
                              A_CHG = 5'h0C, A_WMASK = 5'h10, A_TYPE = 5'h14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic [N-1:0]  pad_in = '0, pad_out, pad_oe;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_chg_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) i_gpio_chg_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  m, d, old, sv_oe, sv_out;
        logic        sv_irq;

        wait_edges(5);
        @(negedge clk) rst = 1'b0;

        // R1: reset values
        check("R1 pad_oe", 32'(pad_oe), 0);
        check("R1 pad_out", 32'(pad_out), 0);
        check("R1 irq", 32'(irq_out), 0);
        bus_read(A_DIR, rd);   check("R1 dir", rd, 0);
        bus_read(A_DATA, rd);  check("R1 data", rd, 0);
        bus_read(A_IEN, rd);   check("R1 ien", rd, 0);
        bus_read(A_CHG, rd);   check("R1 chg", rd, 0);
        bus_read(A_WMASK, rd); check("R1 wmask", rd, 32'h0000_00FF);
        bus_read(A_TYPE, rd);  check("R1 type", rd, 0);

        // R2: exhaustive direction sweep
        for (int v = 0; v < 256; v++) begin
            bus_write(A_DIR, 32'(v));
            check("R2 pad_oe", 32'(pad_oe), 32'(v));
            bus_read(A_DIR, rd);
            check("R2 readback", rd, 32'(v));
        end

        // R3: masked data writes
        for (int a = 0; a < 16; a++) begin
            m   = 8'((a * 37) & 255);
            d   = 8'((a * 91 + 13) & 255);
            old = 8'((a * 53) & 255);
            bus_write(A_WMASK, 32'hFF);
            bus_write(A_DATA, 32'(old));
            check("R3 plain", 32'(pad_out), 32'(old));
            bus_write(A_WMASK, 32'(m));
            bus_write(A_DATA, 32'(d));
            check("R3 masked", 32'(pad_out), 32'((old & ~m) | (d & m)));
        end
        bus_write(A_WMASK, 32'hFF);

        // R4: data read mixes outputs and synchronized inputs
        bus_write(A_DIR, 32'h0F);
        bus_write(A_DATA, 32'hA5);
        @(negedge clk) pad_in = 8'h3C;
        wait_edges(1);
        bus_read(A_DATA, rd);
        check("R4 early", rd, 32'h05);
        wait_edges(1);
        bus_read(A_DATA, rd);
        check("R4 level", rd, 32'h35);

        @(negedge clk) pad_in = 8'h00;
        wait_edges(4);
        bus_write(A_CHG, 32'hFF);
        bus_read(A_CHG, rd);
        check("R6 clear all", rd, 0);

        // R5: each line, rising then falling, with latency
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < N; i++) begin
                @(negedge clk) pad_in[i] = ~pad_in[i];
                wait_edges(2);
                bus_read(A_CHG, rd);
                check("R5 not yet", rd, 0);
                wait_edges(1);
                bus_read(A_CHG, rd);
                check("R5 set", rd, 32'(1) << i);
                bus_write(A_CHG, 32'(1) << i);
                bus_read(A_CHG, rd);
                check("R6 cleared", rd, 0);
            end
        end

        // R6: write-one clears, write-zero keeps
        @(negedge clk) pad_in = 8'hFF;
        wait_edges(4);
        bus_read(A_CHG, rd);
        check("R5 all lines", rd, 32'hFF);
        bus_write(A_CHG, 32'h0F);
        bus_read(A_CHG, rd);
        check("R6 partial", rd, 32'hF0);
        bus_write(A_CHG, 32'h00);
        bus_read(A_CHG, rd);
        check("R6 zero keeps", rd, 32'hF0);

        // R7: edge coincides with clear of the same bit
        @(negedge clk) pad_in[4] = 1'b0;
        wait_edges(2);
        bus_write(A_CHG, 32'h10);
        bus_read(A_CHG, rd);
        check("R7 edge wins", rd, 32'hF0);
        bus_write(A_CHG, 32'hFF);
        bus_read(A_CHG, rd);
        check("R7 then clear", rd, 0);

        // R8: exhaustive enable sweep against a fixed change pattern
        check("R8 idle irq", 32'(irq_out), 0);
        @(negedge clk) pad_in = pad_in ^ 8'h5A;
        wait_edges(4);
        bus_read(A_CHG, rd);
        check("R8 pattern", rd, 32'h5A);
        for (int e = 0; e < 256; e++) begin
            bus_write(A_IEN, 32'(e));
            check("R8 irq", 32'(irq_out), 32'((e & 8'h5A) != 0));
        end
        bus_write(A_IEN, 32'h02);
        check("R8 one line", 32'(irq_out), 1);
        bus_write(A_CHG, 32'h02);
        check("R8 acked", 32'(irq_out), 0);
        bus_write(A_IEN, 32'h08);
        check("R8 other line", 32'(irq_out), 1);

        // R9: bits above the line count
        bus_write(A_DIR, 32'hFFFF_FFFF);
        bus_read(A_DIR, rd);
        check("R9 dir upper", rd, 32'hFF);
        check("R9 pad_oe", 32'(pad_oe), 32'hFF);
        bus_write(A_DATA, 32'h0000_0033);
        bus_write(A_WMASK, 32'hFFFF_FF00);
        bus_read(A_WMASK, rd);
        check("R9 wmask upper", rd, 0);
        bus_write(A_DATA, 32'hFFFF_FFCC);
        check("R3 masked off", 32'(pad_out), 32'h33);
        bus_write(A_WMASK, 32'hFF);

        // R10: type storage has no side effect
        sv_oe = pad_oe; sv_out = pad_out; sv_irq = irq_out;
        bus_write(A_TYPE, 32'hFFFF_FF5A);
        bus_read(A_TYPE, rd);
        check("R10 readback", rd, 32'h5A);
        check("R10 pad_oe", 32'(pad_oe), 32'(sv_oe));
        check("R10 pad_out", 32'(pad_out), 32'(sv_out));
        check("R10 irq", 32'(irq_out), 32'(sv_irq));

        // R11: unmapped and misaligned addresses
        bus_write(5'h18, 32'hFFFF_FFFF);
        bus_read(5'h18, rd);
        check("R11 unmapped read", rd, 0);
        bus_write(5'h01, 32'h0000_0000);
        bus_read(5'h01, rd);
        check("R11 misaligned read", rd, 0);
        bus_read(A_DIR, rd);
        check("R11 dir kept", rd, 32'hFF);
        check("R11 pad_out kept", 32'(pad_out), 32'h33);
        bus_read(A_IEN, rd);
        check("R11 ien kept", rd, 32'h08);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule